// File: doc/BRIEF.md
# D-PHY Test-Port Register Write Sequencer

This block writes one internal register of a D-PHY through the PHY's test-control port. A client offers an 8-bit test code and an 8-bit value on a request/acknowledge interface. The block stores both on acceptance and then drives the port's clear, strobe, enable and 8-bit bus pins through eight fixed phases. Each phase lasts a programmable number of system clocks, so that the port's setup and hold times are met. The PHY takes the code on a falling strobe edge while enable is high. It takes the value on the next rising strobe edge while enable is low. An explicit clear phase comes before both.

The pin state is also mirrored into two 32-bit read-back words. One word holds the clear and strobe bits. The other holds the enable flag and the bus byte. When the last phase ends, the block pulses `done` for one cycle and returns to idle with every pin low. Requests that arrive mid-sequence are dropped.

Top module: `phy_tprog_seq`

## Requirements
- R1: After a clock edge with `rst_n` low, clear, strobe and enable are low, the bus is zero, both read-back words are zero, `done` is low and `req_ready` is high.
- R2: `req_ready` is high exactly when no sequence is running. A request is taken at the edge where `req_valid` and `req_ready` are both high. A request made while a sequence runs is ignored and leaves the running sequence unchanged.
- R3: The first three phases are: clear high with the bus and enable low; then every pin low; then strobe high with enable low and the bus zero.
- R4: The fourth phase keeps strobe high and raises enable with the test code on the bus. The fifth phase drops strobe while enable and the code are held, so the code is captured on the falling edge.
- R5: The sixth phase drops enable and puts the test value on the bus with strobe low. The seventh phase raises strobe while the value is held.
- R6: The eighth phase returns strobe low with the value still on the bus. In the cycle after it, `done` is high for exactly one cycle and every pin is low.
- R7: Each phase lasts `tick_len` clocks, with 0 treated as 1. The length is captured at acceptance, so later changes to `tick_len` do not affect a running sequence.
- R8: Read-back word 0 carries clear at bit 0 and strobe at bit 1. Read-back word 1 carries enable at bit 16 and the bus byte at bits 7:0. All other bits are zero.
- R9: The code and value are captured at acceptance. Changes on `req_code` or `req_data` during a sequence have no effect on the bus.
- R10: Taking `rst_n` low during a sequence returns the block to idle, with all pins low, at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request |
| req_ready | output | 1 | High while idle; request accepted when both high |
| req_code | input | 8 | Test code (PHY register address) |
| req_data | input | 8 | Value to write |
| tick_len | input | 8 | Clocks per phase, 0 acts as 1 |
| tst_clr | output | 1 | Test-port clear pin |
| tst_strobe | output | 1 | Test-port strobe pin |
| tst_en | output | 1 | Test-port enable pin |
| tst_bus | output | 8 | Test-port code/data bus |
| ctl_word0 | output | 32 | Read-back of clear and strobe |
| ctl_word1 | output | 32 | Read-back of enable and bus byte |
| done | output | 1 | One-cycle end-of-write pulse |

## Verification
The pins are decoded from the phase register with no further register. If a request is accepted at clock edge E, phase k shows from edge E+k·L until edge E+(k+1)·L, where L is the effective phase length. `done` and the all-low idle state show from edge E+8·L for one cycle. The bench drives inputs on falling edges and samples on falling edges. It counts the falling edges since acceptance and computes the expected phase at each one as that count divided by L. Every cycle of every phase is compared, together with the first idle cycle and the cycle after it. A reset taken mid-sequence is checked one edge later.

// File: rtl/phy_tprog_pkg.sv
`timescale 1ns/1ps
package phy_tprog_pkg;

   // Phase order is behaviour: the PHY latches the code and the value on
   // specific strobe transitions, so the enum order is the sequence order.
   typedef enum logic [3:0] {
      PH_IDLE      = 4'd0,
      PH_CLEAR     = 4'd1,
      PH_ZERO      = 4'd2,
      PH_STRB_HI   = 4'd3,
      PH_CODE_SET  = 4'd4,
      PH_CODE_FALL = 4'd5,
      PH_DATA_SET  = 4'd6,
      PH_DATA_RISE = 4'd7,
      PH_STRB_LO   = 4'd8
   } phase_e;

   typedef enum logic [1:0] {
      BUS_ZERO = 2'd0,
      BUS_CODE = 2'd1,
      BUS_DATA = 2'd2
   } bus_sel_e;

   typedef struct packed {
      logic     clr;
      logic     strobe;
      logic     en;
      bus_sel_e sel;
   } pin_ctl_t;

   function automatic pin_ctl_t phase_decode(phase_e p);
      pin_ctl_t c;
      c = '{clr: 1'b0, strobe: 1'b0, en: 1'b0, sel: BUS_ZERO};
      case (p)
         PH_CLEAR:     c.clr    = 1'b1;
         PH_STRB_HI:   c.strobe = 1'b1;
         PH_CODE_SET:  begin c.strobe = 1'b1; c.en = 1'b1; c.sel = BUS_CODE; end
         PH_CODE_FALL: begin c.en = 1'b1; c.sel = BUS_CODE; end
         PH_DATA_SET:  c.sel = BUS_DATA;
         PH_DATA_RISE: begin c.strobe = 1'b1; c.sel = BUS_DATA; end
         PH_STRB_LO:   c.sel = BUS_DATA;
         default:      c.clr = 1'b0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/tprog_tick.sv
`timescale 1ns/1ps
module tprog_tick #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [LEN_W-1:0] len,
   output logic             tick
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] cnt;

   assign tick = run && (cnt == len_q - ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q <= ONE;
         cnt   <= '0;
      end else if (start) begin
         len_q <= (len == '0) ? ONE : len;
         cnt   <= '0;
      end else if (run) begin
         cnt <= tick ? '0 : cnt + ONE;
      end
   end

   // R7: the phase counter never runs past the captured length
   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < len_q));

endmodule

// File: rtl/tprog_phase_fsm.sv
`timescale 1ns/1ps
module tprog_phase_fsm
   import phy_tprog_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   req_valid,
   input  logic   tick,
   output phase_e phase,
   output logic   busy,
   output logic   accept,
   output logic   done
);
   assign busy   = (phase != PH_IDLE);
   assign accept = req_valid && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            phase <= PH_CLEAR;
         end else if (busy && tick) begin
            if (phase == PH_STRB_LO) begin
               phase <= PH_IDLE;
               done  <= 1'b1;
            end else begin
               phase <= phase_e'(phase + 4'd1);
            end
         end
      end
   end

   // R2: a sequence only starts from a request
   p_start_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   // R7: the phase only moves on a timer tick
   p_phase_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> $stable(phase));

   // R6: done is a single-cycle pulse
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/tprog_drive.sv
`timescale 1ns/1ps
module tprog_drive
   import phy_tprog_pkg::*;
#(
   parameter int CODE_W   = 8,
   parameter int WORD_W   = 32,
   parameter int CLR_BIT  = 0,
   parameter int STRB_BIT = 1,
   parameter int EN_BIT   = 16,
   parameter bit REG_OUT  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            phase,
   input  logic              start,
   input  logic [CODE_W-1:0] code,
   input  logic [CODE_W-1:0] data,
   output logic              pin_clr,
   output logic              pin_strobe,
   output logic              pin_en,
   output logic [CODE_W-1:0] pin_bus,
   output logic [WORD_W-1:0] word0,
   output logic [WORD_W-1:0] word1
);
   logic [CODE_W-1:0] code_q;
   logic [CODE_W-1:0] data_q;
   pin_ctl_t          ctl;
   logic              nx_clr, nx_strobe, nx_en;
   logic [CODE_W-1:0] nx_bus;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= '0;
         data_q <= '0;
      end else if (start) begin
         code_q <= code;
         data_q <= data;
      end
   end

   always_comb begin
      ctl       = phase_decode(phase);
      nx_clr    = ctl.clr;
      nx_strobe = ctl.strobe;
      nx_en     = ctl.en;
      case (ctl.sel)
         BUS_CODE: nx_bus = code_q;
         BUS_DATA: nx_bus = data_q;
         default:  nx_bus = '0;
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg_pins
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pin_clr    <= 1'b0;
               pin_strobe <= 1'b0;
               pin_en     <= 1'b0;
               pin_bus    <= '0;
            end else begin
               pin_clr    <= nx_clr;
               pin_strobe <= nx_strobe;
               pin_en     <= nx_en;
               pin_bus    <= nx_bus;
            end
         end
      end else begin : g_comb_pins
         assign pin_clr    = nx_clr;
         assign pin_strobe = nx_strobe;
         assign pin_en     = nx_en;
         assign pin_bus    = nx_bus;
      end
   endgenerate

   always_comb begin
      word0                 = '0;
      word0[CLR_BIT]        = pin_clr;
      word0[STRB_BIT]       = pin_strobe;
      word1                 = '0;
      word1[EN_BIT]         = pin_en;
      word1[CODE_W-1:0]     = pin_bus;
   end

   // R3: clear is never combined with strobe or enable
   p_clr_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pin_clr |-> (!pin_strobe && !pin_en));

endmodule

// File: rtl/phy_tprog_seq.sv
`timescale 1ns/1ps
module phy_tprog_seq
   import phy_tprog_pkg::*;
#(
   parameter int CODE_W   = 8,
   parameter int LEN_W    = 8,
   parameter int WORD_W   = 32,
   parameter int CLR_BIT  = 0,
   parameter int STRB_BIT = 1,
   parameter int EN_BIT   = 16,
   parameter bit REG_OUT  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CODE_W-1:0] req_code,
   input  logic [CODE_W-1:0] req_data,
   input  logic [LEN_W-1:0]  tick_len,
   output logic              tst_clr,
   output logic              tst_strobe,
   output logic              tst_en,
   output logic [CODE_W-1:0] tst_bus,
   output logic [WORD_W-1:0] ctl_word0,
   output logic [WORD_W-1:0] ctl_word1,
   output logic              done
);
   localparam int FIELD_TOP = (STRB_BIT > CLR_BIT) ? STRB_BIT : CLR_BIT;

   generate
      if (EN_BIT >= WORD_W || FIELD_TOP >= WORD_W) begin : g_bad_pos
         $error("control bit position outside the read-back word");
      end
      if (CODE_W > EN_BIT) begin : g_bad_overlap
         $error("bus field overlaps the enable bit");
      end
      if (CLR_BIT == STRB_BIT) begin : g_bad_word0
         $error("clear and strobe share a bit");
      end
      if (LEN_W < 1 || CODE_W < 1) begin : g_bad_width
         $error("widths must be positive");
      end
   endgenerate

   phase_e phase;
   logic   busy;
   logic   accept;
   logic   tick;

   assign req_ready = !busy;

   tprog_phase_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .tick      (tick),
      .phase     (phase),
      .busy      (busy),
      .accept    (accept),
      .done      (done)
   );

   tprog_tick #(.LEN_W(LEN_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .run   (busy),
      .len   (tick_len),
      .tick  (tick)
   );

   tprog_drive #(
      .CODE_W   (CODE_W),
      .WORD_W   (WORD_W),
      .CLR_BIT  (CLR_BIT),
      .STRB_BIT (STRB_BIT),
      .EN_BIT   (EN_BIT),
      .REG_OUT  (REG_OUT)
   ) u_drive (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase),
      .start      (accept),
      .code       (req_code),
      .data       (req_data),
      .pin_clr    (tst_clr),
      .pin_strobe (tst_strobe),
      .pin_en     (tst_en),
      .pin_bus    (tst_bus),
      .word0      (ctl_word0),
      .word1      (ctl_word1)
   );

   // R4: the code stays on the bus across the falling strobe edge
   p_code_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(tst_strobe) && tst_en) |-> ($stable(tst_bus) && $past(tst_en)));

   // R5: a rising strobe edge never carries enable and keeps the bus steady
   p_data_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tst_strobe) |-> (!tst_en && $stable(tst_bus)));

   generate
      if (!REG_OUT) begin : g_done_chk
         // R6: when done is shown, the test port is quiet
         p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> (!tst_clr && !tst_strobe && !tst_en && tst_bus == '0));
      end
   endgenerate

endmodule

// File: tb/phy_tprog_seq_test.sv
`timescale 1ns/1ps
module phy_tprog_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [7:0]  req_code = '0;
   logic [7:0]  req_data = '0;
   logic [7:0]  tick_len = 8'd1;
   logic        tst_clr, tst_strobe, tst_en;
   logic [7:0]  tst_bus;
   logic [31:0] ctl_word0, ctl_word1;
   logic        done;

   int n_checks = 0;
   int n_fails  = 0;

   always #2 clk = ~clk;

   phy_tprog_seq uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_code   (req_code),
      .req_data   (req_data),
      .tick_len   (tick_len),
      .tst_clr    (tst_clr),
      .tst_strobe (tst_strobe),
      .tst_en     (tst_en),
      .tst_bus    (tst_bus),
      .ctl_word0  (ctl_word0),
      .ctl_word1  (ctl_word1),
      .done       (done)
   );

   // packed observation: clr, strobe, en, bus, w0, w1, done, ready
   function automatic logic [82:0] observe();
      return {tst_clr, tst_strobe, tst_en, tst_bus, ctl_word0, ctl_word1, done, req_ready};
   endfunction

   // expected pins for phase k (0..7), 8 = first idle cycle, 9 = quiet idle
   function automatic logic [82:0] expect_at(int k, logic [7:0] c, logic [7:0] d);
      logic clr, stb, en, dn, rdy;
      logic [7:0]  bus;
      logic [31:0] w0, w1;
      clr = 0; stb = 0; en = 0; bus = 0; dn = 0; rdy = 0;
      case (k)
         0: clr = 1;
         1: ;
         2: stb = 1;
         3: begin stb = 1; en = 1; bus = c; end
         4: begin en = 1; bus = c; end
         5: bus = d;
         6: begin stb = 1; bus = d; end
         7: bus = d;
         8: begin dn = 1; rdy = 1; end
         default: rdy = 1;
      endcase
      w0 = {30'd0, stb, clr};
      w1 = {15'd0, en, 8'd0, bus};
      return {clr, stb, en, bus, w0, w1, dn, rdy};
   endfunction

   function automatic string tag_of(int k);
      case (k)
         0, 1, 2: return "R3";
         3, 4:    return "R4";
         5, 6:    return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(string req, logic [82:0] act, logic [82:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h (fields clr,strb,en,bus,w0,w1,done,ready; R8 word layout)",
                  req, act, exp);
      end
   endtask

   // One full write. inject: mid-sequence request with other code/data/len (R2, R9, R7)
   task automatic run_write(logic [7:0] c, logic [7:0] d, logic [7:0] len, bit inject);
      int L;
      L = (len == 0) ? 1 : int'(len);
      @(negedge clk);
      req_code = c; req_data = d; tick_len = len; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int j = 0; j <= 8 * L + 1; j++) begin
         int k;
         k = (j < 8 * L) ? (j / L) : (j == 8 * L ? 8 : 9);
         if (inject)
            check($sformatf("%s R2 R9 R7 inject j=%0d", tag_of(k), j), observe(), expect_at(k, c, d));
         else
            check($sformatf("%s R7 len=%0d j=%0d", tag_of(k), len, j), observe(), expect_at(k, c, d));
         if (inject && j == 2) begin
            req_valid = 1'b1; req_code = ~c; req_data = ~d; tick_len = len + 8'd3;
         end
         if (inject && j == 3 * L + 1) begin
            req_valid = 1'b0;
         end
         if (j < 8 * L + 1) @(negedge clk);
      end
      req_valid = 1'b0;
      tick_len = len;
   endtask

   task automatic reset_check();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset state", observe(), expect_at(9, 8'h0, 8'h0));
      rst_n = 1'b1;
   endtask

   task automatic midrun_reset();
      @(negedge clk);
      req_code = 8'h5A; req_data = 8'hC3; tick_len = 8'd2; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (7) @(negedge clk);
      check("R10 before reset, code phase", observe(), expect_at(3, 8'h5A, 8'hC3));
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 reset mid-sequence", observe(), expect_at(9, 8'h0, 8'h0));
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 stays idle after reset", observe(), expect_at(9, 8'h0, 8'h0));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin : main
      repeat (2) @(negedge clk);
      check("R1 reset state", observe(), expect_at(9, 8'h0, 8'h0));
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 idle ready", observe(), expect_at(9, 8'h0, 8'h0));
      run_write(8'h44, 8'h2C, 8'd1, 1'b0);
      run_write(8'hA5, 8'h5A, 8'd0, 1'b0);   // R7: zero acts as one
      run_write(8'hFF, 8'h81, 8'd3, 1'b0);
      run_write(8'h12, 8'hE7, 8'd2, 1'b1);   // R2/R9 busy request ignored
      midrun_reset();
      run_write(8'h01, 8'h80, 8'd4, 1'b0);
      reset_check();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule